// File: doc/BRIEF.md
# Stacked Multi-Window Overlay Timing

The block decides, one pixel at a time, what a video output stage shows when a column of up to four small picture windows sits on top of the main raster. It takes the main pixel and line counters and a set of configuration fields: a column position, a size choice, per-window enable and blanking bits, a live-window select, a border color code and a solid-fill code. From these it works out whether the current pixel belongs to a window and, if so, to which part of it. It then produces a display select, a color code, the index of the window involved and, for picture pixels, the read coordinates into that window's stored picture.

The windows sit in one column, each directly under the previous one with no gap, and every window carries its own border. A small size and a large size exist. The column origin is set by two 6-bit position fields. The origin is pulled back when needed so the column always ends before the horizontal and vertical limits that protect the main sync intervals. Exactly one window is flagged live and the others are treated as stills by the memory side. All outputs are registered, so they appear one clock after the counters and configuration that produce them.

Top module: `stacked_overlay_timing`

## Requirements
- R1: While rst_n is low, on every clock edge, sel_o (0 main, 1 picture, 2 border, 3 solid color), color_o, win_idx_o, rd_x_o, rd_y_o and live_o are cleared to zero.
- R2: With size_big low, each window is 84 pixels by 53 lines and four windows are stacked. With size_big high, each window is 114 pixels by 71 lines and three are stacked. Window k starts k window heights below the column origin. Window 0 is the top window and no window index 3 appears in the large size.
- R3: The outermost 3 pixels on the left and right of each window and the outermost 2 lines at its top and bottom form the border. border_code 0..5 shows sel 2 with color_o equal to the code (0 black, 1 70% white, 2 white, 3 red, 4 green, 5 blue). Codes 6 and 7 make the border transparent, and those pixels show main (sel 0).
- R4: The unclamped column origin is pixel 16 + 10*x_pos and line 20 + 4*y_pos.
- R5: If the window would cross pixel 700, the horizontal origin becomes 700 minus the window width. If the column would cross line 260, the vertical origin becomes 260 minus the column height (window count times window height).
- R6: A window whose win_on bit (bit k for window k) is 0 shows main video over its whole area, border included. Pixels outside the column also show main. When sel_o is 0, color_o, win_idx_o, rd_x_o, rd_y_o and live_o are 0.
- R7: Inside an enabled window's border, a nonzero fill_code shows sel 3 with color 3 (red) for code 1, 4 (green) for code 2 and 5 (blue) for code 3. Fill takes priority over blanking.
- R8: With fill_code 0, an enabled window whose win_blank bit is set shows sel 3 and color 0 (black) inside its border.
- R9: A picture pixel (sel 1) gives rd_x_o and rd_y_o equal to its pixel and line offset from the first pixel inside the border. The read coordinates are zero for every other select.
- R10: live_o is 1 only for picture pixels of the live window, which is window live_sel. In the large size, live_sel 3 selects window 2.
- R11: Outputs change only on the clock edge that follows a change of the inputs, with one register stage of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| h_cnt | input | 10 | Main raster pixel counter |
| v_cnt | input | 9 | Main raster line counter |
| x_pos | input | 6 | Column horizontal position step |
| y_pos | input | 6 | Column vertical position step |
| size_big | input | 1 | 0 small windows, 1 large windows |
| win_on | input | 4 | Per-window enable, bit 0 top |
| win_blank | input | 4 | Per-window force-to-black |
| live_sel | input | 2 | Live window select |
| border_code | input | 3 | Border color or transparent |
| fill_code | input | 2 | Solid fill color, 0 for none |
| sel_o | output | 2 | 0 main, 1 picture, 2 border, 3 solid |
| color_o | output | 3 | Color code for border and solid pixels |
| win_idx_o | output | 2 | Window owning the pixel |
| rd_x_o | output | 7 | Picture read column within window |
| rd_y_o | output | 7 | Picture read line within window |
| live_o | output | 1 | Picture pixel belongs to the live window |

## Verification
The bench concentrates on edge positions. These are the last border pixel and line next to the first picture pixel, the seam between two stacked windows, and the first pixel past the column. A design with an off-by-one there would shift the picture by one pixel or leave a one-line gap between windows. Both clamp cases run at the top position codes in both sizes; a missing clamp would run the column past the sync limits. The bench also covers the priority cases of fill over blank, transparent border over enabled window and disabled window over everything, plus a live code of 3 in the large size. A wrong priority or a missing remap there would paint a solid color over live video or flag no window as live.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

   typedef enum logic [1:0] {
      SEL_MAIN   = 2'd0,
      SEL_PIC    = 2'd1,
      SEL_BORDER = 2'd2,
      SEL_SOLID  = 2'd3
   } ovl_sel_e;

   localparam logic [2:0] CLR_BLACK = 3'd0;
   localparam logic [2:0] CLR_GRAY  = 3'd1;
   localparam logic [2:0] CLR_WHITE = 3'd2;
   localparam logic [2:0] CLR_RED   = 3'd3;
   localparam logic [2:0] CLR_GREEN = 3'd4;
   localparam logic [2:0] CLR_BLUE  = 3'd5;

   // returns {transparent, color}
   function automatic logic [3:0] border_lookup(input logic [2:0] code);
      logic [3:0] r;
      case (code)
         3'd0:    r = {1'b0, CLR_BLACK};
         3'd1:    r = {1'b0, CLR_GRAY};
         3'd2:    r = {1'b0, CLR_WHITE};
         3'd3:    r = {1'b0, CLR_RED};
         3'd4:    r = {1'b0, CLR_GREEN};
         3'd5:    r = {1'b0, CLR_BLUE};
         default: r = {1'b1, CLR_BLACK};
      endcase
      return r;
   endfunction

   function automatic logic [2:0] fill_lookup(input logic [1:0] code);
      logic [2:0] r;
      case (code)
         2'd1:    r = CLR_RED;
         2'd2:    r = CLR_GREEN;
         2'd3:    r = CLR_BLUE;
         default: r = CLR_BLACK;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ovl_place.sv
module ovl_place #(
   parameter int CW      = 12,
   parameter int XPW     = 6,
   parameter int YPW     = 6,
   parameter int NW      = 3,
   parameter int MAX_WIN = 4,
   parameter int BIG_WIN = 3,
   parameter int SMALL_W = 84,
   parameter int SMALL_H = 53,
   parameter int BIG_W   = 114,
   parameter int BIG_H   = 71,
   parameter int H_BASE  = 16,
   parameter int H_STEP  = 10,
   parameter int H_LIMIT = 700,
   parameter int V_BASE  = 20,
   parameter int V_STEP  = 4,
   parameter int V_LIMIT = 260
) (
   input  logic           size_big,
   input  logic [XPW-1:0] x_pos,
   input  logic [YPW-1:0] y_pos,
   output logic [CW-1:0]  x0,
   output logic [CW-1:0]  y0,
   output logic [CW-1:0]  win_w,
   output logic [CW-1:0]  win_h,
   output logic [NW-1:0]  n_win
);
   localparam int SMALL_COL = SMALL_H * MAX_WIN;
   localparam int BIG_COL   = BIG_H * BIG_WIN;

   logic [CW-1:0] col_h;
   logic [CW-1:0] x_raw;
   logic [CW-1:0] y_raw;

   always_comb begin
      win_w = size_big ? CW'(BIG_W)   : CW'(SMALL_W);
      win_h = size_big ? CW'(BIG_H)   : CW'(SMALL_H);
      col_h = size_big ? CW'(BIG_COL) : CW'(SMALL_COL);
      n_win = size_big ? NW'(BIG_WIN) : NW'(MAX_WIN);
      x_raw = CW'(H_BASE) + CW'(x_pos) * CW'(H_STEP);
      y_raw = CW'(V_BASE) + CW'(y_pos) * CW'(V_STEP);
      // pull the column back so it ends before the sync keep-out limits
      x0 = (x_raw + win_w > CW'(H_LIMIT)) ? CW'(H_LIMIT) - win_w : x_raw;
      y0 = (y_raw + col_h > CW'(V_LIMIT)) ? CW'(V_LIMIT) - col_h : y_raw;
   end
endmodule

// File: rtl/ovl_win_hit.sv
module ovl_win_hit #(
   parameter int CW    = 12,
   parameter int NW    = 3,
   parameter int IDX   = 0,
   parameter int BRD_X = 3,
   parameter int BRD_Y = 2
) (
   input  logic [CW-1:0] h,
   input  logic [CW-1:0] v,
   input  logic [CW-1:0] x0,
   input  logic [CW-1:0] y0,
   input  logic [CW-1:0] win_w,
   input  logic [CW-1:0] win_h,
   input  logic [NW-1:0] n_win,
   output logic          hit,
   output logic          on_edge,
   output logic [CW-1:0] dx,
   output logic [CW-1:0] dy
);
   logic [CW-1:0] top;
   logic          exists;
   logic          in_x;
   logic          in_y;

   always_comb begin
      top     = y0 + CW'(IDX) * win_h;
      exists  = NW'(IDX) < n_win;
      in_x    = (h >= x0) && (h < x0 + win_w);
      in_y    = (v >= top) && (v < top + win_h);
      hit     = exists && in_x && in_y;
      dx      = h - x0;
      dy      = v - top;
      on_edge = (dx < CW'(BRD_X)) || (dx >= win_w - CW'(BRD_X)) ||
                (dy < CW'(BRD_Y)) || (dy >= win_h - CW'(BRD_Y));
   end
endmodule

// File: rtl/ovl_pix_mux.sv
module ovl_pix_mux
   import ovl_pkg::*;
#(
   parameter int CW      = 12,
   parameter int MAX_WIN = 4,
   parameter int BIG_WIN = 3,
   parameter int IW      = 2,
   parameter int RXW     = 7,
   parameter int RYW     = 7,
   parameter int BRD_X   = 3,
   parameter int BRD_Y   = 2
) (
   input  logic [MAX_WIN-1:0]         hit,
   input  logic [MAX_WIN-1:0]         on_edge,
   input  logic [MAX_WIN-1:0][CW-1:0] dx,
   input  logic [MAX_WIN-1:0][CW-1:0] dy,
   input  logic [MAX_WIN-1:0]         win_on,
   input  logic [MAX_WIN-1:0]         win_blank,
   input  logic [IW-1:0]              live_sel,
   input  logic                       size_big,
   input  logic [2:0]                 border_code,
   input  logic [1:0]                 fill_code,
   output logic [1:0]                 sel,
   output logic [2:0]                 color,
   output logic [IW-1:0]              idx,
   output logic [RXW-1:0]             rd_x,
   output logic [RYW-1:0]             rd_y,
   output logic                       live
);
   logic          any;
   logic [IW-1:0] ksel;
   logic [IW-1:0] live_idx;
   logic [3:0]    brd;

   always_comb begin
      any  = 1'b0;
      ksel = '0;
      for (int k = 0; k < MAX_WIN; k++) begin
         if (hit[k] && !any) begin
            any  = 1'b1;
            ksel = IW'(k);
         end
      end
      live_idx = (size_big && (live_sel > IW'(BIG_WIN - 1))) ? IW'(BIG_WIN - 1) : live_sel;
      brd   = border_lookup(border_code);
      sel   = SEL_MAIN;
      color = CLR_BLACK;
      idx   = '0;
      rd_x  = '0;
      rd_y  = '0;
      live  = 1'b0;
      if (any && win_on[ksel]) begin
         if (on_edge[ksel]) begin
            if (!brd[3]) begin
               sel   = SEL_BORDER;
               color = brd[2:0];
               idx   = ksel;
            end
         end else if (fill_code != 2'd0) begin
            sel   = SEL_SOLID;
            color = fill_lookup(fill_code);
            idx   = ksel;
         end else if (win_blank[ksel]) begin
            sel   = SEL_SOLID;
            color = CLR_BLACK;
            idx   = ksel;
         end else begin
            sel   = SEL_PIC;
            idx   = ksel;
            rd_x  = RXW'(dx[ksel] - CW'(BRD_X));
            rd_y  = RYW'(dy[ksel] - CW'(BRD_Y));
            live  = (ksel == live_idx);
         end
      end
   end
endmodule

// File: rtl/stacked_overlay_timing.sv
module stacked_overlay_timing #(
   parameter int HCW     = 10,
   parameter int VCW     = 9,
   parameter int XPW     = 6,
   parameter int YPW     = 6,
   parameter int MAX_WIN = 4,
   parameter int BIG_WIN = 3,
   parameter int SMALL_W = 84,
   parameter int SMALL_H = 53,
   parameter int BIG_W   = 114,
   parameter int BIG_H   = 71,
   parameter int BRD_X   = 3,
   parameter int BRD_Y   = 2,
   parameter int H_BASE  = 16,
   parameter int H_STEP  = 10,
   parameter int H_LIMIT = 700,
   parameter int V_BASE  = 20,
   parameter int V_STEP  = 4,
   parameter int V_LIMIT = 260,
   parameter int IW      = $clog2(MAX_WIN),
   parameter int RXW     = $clog2(BIG_W),
   parameter int RYW     = $clog2(BIG_H)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HCW-1:0]     h_cnt,
   input  logic [VCW-1:0]     v_cnt,
   input  logic [XPW-1:0]     x_pos,
   input  logic [YPW-1:0]     y_pos,
   input  logic               size_big,
   input  logic [MAX_WIN-1:0] win_on,
   input  logic [MAX_WIN-1:0] win_blank,
   input  logic [IW-1:0]      live_sel,
   input  logic [2:0]         border_code,
   input  logic [1:0]         fill_code,
   output logic [1:0]         sel_o,
   output logic [2:0]         color_o,
   output logic [IW-1:0]      win_idx_o,
   output logic [RXW-1:0]     rd_x_o,
   output logic [RYW-1:0]     rd_y_o,
   output logic               live_o
);
   localparam int CW = ((HCW > VCW) ? HCW : VCW) + 2;
   localparam int NW = $clog2(MAX_WIN + 1);

   // elaboration-time parameter checks
   if (BIG_WIN > MAX_WIN) begin : g_bad_win
      $error("large window count exceeds small window count");
   end
   if ((2 * BRD_X >= SMALL_W) || (2 * BRD_Y >= SMALL_H)) begin : g_bad_brd
      $error("border leaves no picture area");
   end
   if ((H_BASE + BIG_W > H_LIMIT) || (V_BASE + BIG_H * BIG_WIN > V_LIMIT)) begin : g_bad_lim
      $error("window column cannot fit inside the keep-out limits");
   end
   if ((H_LIMIT >= (1 << HCW)) || (V_LIMIT >= (1 << VCW))) begin : g_bad_cnt
      $error("counter width too small for limits");
   end
   if ((BIG_W - 2 * BRD_X > (1 << RXW)) || (BIG_H - 2 * BRD_Y > (1 << RYW))) begin : g_bad_rd
      $error("read coordinate width too small");
   end

   logic [CW-1:0] x0, y0, win_w, win_h;
   logic [NW-1:0] n_win;
   logic [CW-1:0] h_ext, v_ext;

   assign h_ext = CW'(h_cnt);
   assign v_ext = CW'(v_cnt);

   ovl_place #(
      .CW(CW), .XPW(XPW), .YPW(YPW), .NW(NW),
      .MAX_WIN(MAX_WIN), .BIG_WIN(BIG_WIN),
      .SMALL_W(SMALL_W), .SMALL_H(SMALL_H), .BIG_W(BIG_W), .BIG_H(BIG_H),
      .H_BASE(H_BASE), .H_STEP(H_STEP), .H_LIMIT(H_LIMIT),
      .V_BASE(V_BASE), .V_STEP(V_STEP), .V_LIMIT(V_LIMIT)
   ) u_place (
      .size_big (size_big),
      .x_pos    (x_pos),
      .y_pos    (y_pos),
      .x0       (x0),
      .y0       (y0),
      .win_w    (win_w),
      .win_h    (win_h),
      .n_win    (n_win)
   );

   logic [MAX_WIN-1:0]         hit;
   logic [MAX_WIN-1:0]         on_edge;
   logic [MAX_WIN-1:0][CW-1:0] dx;
   logic [MAX_WIN-1:0][CW-1:0] dy;

   for (genvar k = 0; k < MAX_WIN; k++) begin : g_win
      ovl_win_hit #(
         .CW(CW), .NW(NW), .IDX(k), .BRD_X(BRD_X), .BRD_Y(BRD_Y)
      ) u_hit (
         .h       (h_ext),
         .v       (v_ext),
         .x0      (x0),
         .y0      (y0),
         .win_w   (win_w),
         .win_h   (win_h),
         .n_win   (n_win),
         .hit     (hit[k]),
         .on_edge (on_edge[k]),
         .dx      (dx[k]),
         .dy      (dy[k])
      );
   end

   logic [1:0]     sel_d;
   logic [2:0]     color_d;
   logic [IW-1:0]  idx_d;
   logic [RXW-1:0] rd_x_d;
   logic [RYW-1:0] rd_y_d;
   logic           live_d;

   ovl_pix_mux #(
      .CW(CW), .MAX_WIN(MAX_WIN), .BIG_WIN(BIG_WIN), .IW(IW),
      .RXW(RXW), .RYW(RYW), .BRD_X(BRD_X), .BRD_Y(BRD_Y)
   ) u_mux (
      .hit         (hit),
      .on_edge     (on_edge),
      .dx          (dx),
      .dy          (dy),
      .win_on      (win_on),
      .win_blank   (win_blank),
      .live_sel    (live_sel),
      .size_big    (size_big),
      .border_code (border_code),
      .fill_code   (fill_code),
      .sel         (sel_d),
      .color       (color_d),
      .idx         (idx_d),
      .rd_x        (rd_x_d),
      .rd_y        (rd_y_d),
      .live        (live_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_o     <= '0;
         color_o   <= '0;
         win_idx_o <= '0;
         rd_x_o    <= '0;
         rd_y_o    <= '0;
         live_o    <= 1'b0;
      end else begin
         sel_o     <= sel_d;
         color_o   <= color_d;
         win_idx_o <= idx_d;
         rd_x_o    <= rd_x_d;
         rd_y_o    <= rd_y_d;
         live_o    <= live_d;
      end
   end
endmodule

// File: rtl/ovl_checker.sv
module ovl_checker #(
   parameter int MAX_WIN = 4,
   parameter int BIG_WIN = 3,
   parameter int SMALL_W = 84,
   parameter int SMALL_H = 53,
   parameter int BIG_W   = 114,
   parameter int BIG_H   = 71,
   parameter int BRD_X   = 3,
   parameter int BRD_Y   = 2,
   parameter int IW      = 2,
   parameter int RXW     = 7,
   parameter int RYW     = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               size_big,
   input logic [MAX_WIN-1:0] win_on,
   input logic [MAX_WIN-1:0] win_blank,
   input logic [1:0]         fill_code,
   input logic [1:0]         sel_o,
   input logic [2:0]         color_o,
   input logic [IW-1:0]      win_idx_o,
   input logic [RXW-1:0]     rd_x_o,
   input logic [RYW-1:0]     rd_y_o,
   input logic               live_o
);
   localparam int SPX = SMALL_W - 2 * BRD_X;
   localparam int BPX = BIG_W - 2 * BRD_X;
   localparam int SPY = SMALL_H - 2 * BRD_Y;
   localparam int BPY = BIG_H - 2 * BRD_Y;

   p_on_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o != 2'd0) |-> ((($past(win_on) >> win_idx_o) & MAX_WIN'(1)) != '0));

   p_big_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_o != 2'd0) && $past(size_big)) |-> (int'(win_idx_o) < BIG_WIN));

   p_rdx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o == 2'd1) |-> (int'(rd_x_o) < ($past(size_big) ? BPX : SPX)));

   p_rdy_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o == 2'd1) |-> (int'(rd_y_o) < ($past(size_big) ? BPY : SPY)));

   p_rd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o != 2'd1) |-> (rd_x_o == '0 && rd_y_o == '0));

   p_live_pic_r10: assert property (@(posedge clk) disable iff (!rst_n)
      live_o |-> (sel_o == 2'd1));

   p_fill_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o == 2'd1) |-> ($past(fill_code) == 2'd0));

   p_blank_black_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_o == 2'd3) && ($past(fill_code) == 2'd0)) |->
      ((color_o == 3'd0) && ((($past(win_blank) >> win_idx_o) & MAX_WIN'(1)) != '0)));
endmodule

bind stacked_overlay_timing ovl_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .size_big  (size_big),
   .win_on    (win_on),
   .win_blank (win_blank),
   .fill_code (fill_code),
   .sel_o     (sel_o),
   .color_o   (color_o),
   .win_idx_o (win_idx_o),
   .rd_x_o    (rd_x_o),
   .rd_y_o    (rd_y_o),
   .live_o    (live_o)
);

// File: tb/sim_stacked_overlay_timing.sv
`timescale 1ns/1ps
module sim_stacked_overlay_timing;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] h_cnt = '0;
   logic [8:0] v_cnt = '0;
   logic [5:0] x_pos = '0;
   logic [5:0] y_pos = '0;
   logic       size_big = 1'b0;
   logic [3:0] win_on = '0;
   logic [3:0] win_blank = '0;
   logic [1:0] live_sel = '0;
   logic [2:0] border_code = '0;
   logic [1:0] fill_code = '0;
   logic [1:0] sel_o;
   logic [2:0] color_o;
   logic [1:0] win_idx_o;
   logic [6:0] rd_x_o;
   logic [6:0] rd_y_o;
   logic       live_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   stacked_overlay_timing u0 (
      .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
      .x_pos(x_pos), .y_pos(y_pos), .size_big(size_big),
      .win_on(win_on), .win_blank(win_blank), .live_sel(live_sel),
      .border_code(border_code), .fill_code(fill_code),
      .sel_o(sel_o), .color_o(color_o), .win_idx_o(win_idx_o),
      .rd_x_o(rd_x_o), .rd_y_o(rd_y_o), .live_o(live_o)
   );

   function automatic int g_w();  return size_big ? 114 : 84; endfunction
   function automatic int g_h();  return size_big ? 71 : 53;  endfunction
   function automatic int g_n();  return size_big ? 3 : 4;    endfunction
   function automatic int g_x0();
      int xr = 16 + 10 * int'(x_pos);
      return (xr + g_w() > 700) ? 700 - g_w() : xr;
   endfunction
   function automatic int g_y0();
      int yr = 20 + 4 * int'(y_pos);
      int ch = g_n() * g_h();
      return (yr + ch > 260) ? 260 - ch : yr;
   endfunction

   task automatic model(output int es, output int ec, output int ei,
                        output int erx, output int ery, output int el);
      int x0, y0, w, hh, k, dx, dy, lidx, hc, vc;
      bit edge_b;
      es = 0; ec = 0; ei = 0; erx = 0; ery = 0; el = 0;
      w = g_w(); hh = g_h(); x0 = g_x0(); y0 = g_y0();
      hc = int'(h_cnt); vc = int'(v_cnt);
      if (hc >= x0 && hc < x0 + w && vc >= y0 && vc < y0 + g_n() * hh) begin
         k  = (vc - y0) / hh;
         dx = hc - x0;
         dy = vc - y0 - k * hh;
         if (win_on[k]) begin
            edge_b = (dx < 3) || (dx >= w - 3) || (dy < 2) || (dy >= hh - 2);
            if (edge_b) begin
               if (border_code < 3'd6) begin es = 2; ec = int'(border_code); ei = k; end
            end else if (fill_code != 2'd0) begin
               es = 3; ec = int'(fill_code) + 2; ei = k;
            end else if (win_blank[k]) begin
               es = 3; ec = 0; ei = k;
            end else begin
               es = 1; ei = k; erx = dx - 3; ery = dy - 2;
               lidx = (size_big && live_sel == 2'd3) ? 2 : int'(live_sel);
               el = (k == lidx) ? 1 : 0;
            end
         end
      end
   endtask

   task automatic compare(input string tag);
      int es, ec, ei, erx, ery, el;
      string req;
      model(es, ec, ei, erx, ery, el);
      req = tag;
      if (req == "") begin
         case (es)
            0: req = "R6";
            1: req = "R9";
            2: req = "R3";
            default: req = (fill_code != 0) ? "R7" : "R8";
         endcase
      end
      checks++;
      if (int'(sel_o) != es || int'(color_o) != ec || int'(win_idx_o) != ei ||
          int'(rd_x_o) != erx || int'(rd_y_o) != ery) begin
         errors++;
         $display("FAIL %s h=%0d v=%0d: sel/color/idx/rx/ry got %0d/%0d/%0d/%0d/%0d exp %0d/%0d/%0d/%0d/%0d",
                  req, h_cnt, v_cnt, sel_o, color_o, win_idx_o, rd_x_o, rd_y_o,
                  es, ec, ei, erx, ery);
      end else if (int'(live_o) != el) begin
         errors++;
         $display("FAIL R10 h=%0d v=%0d: live got %0d exp %0d", h_cnt, v_cnt, live_o, el);
      end
   endtask

   task automatic px(input int h, input int v, input string tag);
      @(negedge clk);
      h_cnt = 10'(h);
      v_cnt = 9'(v);
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic cfg(input int x, input int y, input bit big, input int on,
                      input int blank, input int live, input int brd, input int fill);
      @(negedge clk);
      x_pos = 6'(x); y_pos = 6'(y); size_big = big;
      win_on = 4'(on); win_blank = 4'(blank); live_sel = 2'(live);
      border_code = 3'(brd); fill_code = 2'(fill);
   endtask

   initial begin
      int x0, y0;
      void'($urandom(32'd1234));
      // R1: reset clears outputs even with a picture pixel on the inputs
      win_on = 4'hF; h_cnt = 10'd30; v_cnt = 9'd30;
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (sel_o != 0 || color_o != 0 || win_idx_o != 0 || rd_x_o != 0 || rd_y_o != 0 || live_o != 0) begin
         errors++;
         $display("FAIL R1 reset outputs got sel=%0d color=%0d idx=%0d rx=%0d ry=%0d live=%0d exp all 0",
                  sel_o, color_o, win_idx_o, rd_x_o, rd_y_o, live_o);
      end
      rst_n = 1'b1;

      // R4: origin mapping, small size
      cfg(0, 0, 0, 4'hF, 0, 0, 1, 0);
      px(16, 20, "R4");  px(15, 20, "R4");  px(16, 19, "R4");
      cfg(5, 7, 0, 4'hF, 0, 0, 1, 0);
      px(66, 48, "R4");  px(65, 48, "R4");  px(66, 47, "R4");

      // R3: border thickness and transparency
      cfg(0, 0, 0, 4'hF, 0, 0, 4, 0);
      px(18, 30, "R3");  px(19, 30, "R9");  px(30, 21, "R3");  px(30, 22, "R9");
      px(97, 30, "R3");  px(96, 30, "R9");  px(99, 30, "R3");  px(100, 30, "R6");
      cfg(0, 0, 0, 4'hF, 0, 0, 7, 0);
      px(17, 30, "R3");  px(20, 30, "R9");

      // R2: stacking seams and counts
      cfg(0, 0, 0, 4'hF, 0, 0, 0, 0);
      px(40, 72, "R2");  px(40, 73, "R2");  px(40, 231, "R2");  px(40, 232, "R2");
      cfg(0, 0, 1, 4'hF, 0, 0, 2, 0);
      px(40, 90, "R2");  px(40, 91, "R2");  px(40, 232, "R2");  px(40, 233, "R2");

      // R5: clamp at the largest position codes
      cfg(63, 63, 0, 4'hF, 0, 0, 5, 0);
      px(699, 48, "R5"); px(700, 48, "R5"); px(616, 259, "R5"); px(615, 100, "R5"); px(616, 47, "R5");
      cfg(63, 63, 1, 4'hF, 0, 0, 5, 0);
      px(586, 47, "R5"); px(585, 47, "R5"); px(699, 259, "R5"); px(650, 100, "R5");

      // R6 / R7 / R8 priorities
      cfg(0, 0, 0, 4'b1101, 4'b0011, 0, 2, 0);
      px(40, 90, "R6");  px(17, 80, "R6");  px(40, 40, "R8");
      cfg(0, 0, 0, 4'hF, 4'hF, 0, 2, 2);
      px(40, 40, "R7");  px(40, 100, "R7"); px(16, 40, "R3");

      // R10: live select with remap in large size
      cfg(0, 0, 1, 4'hF, 0, 3, 0, 0);
      px(40, 170, "R10"); px(40, 100, "R10"); px(40, 40, "R10");
      cfg(0, 0, 0, 4'hF, 0, 3, 0, 0);
      px(40, 200, "R10"); px(40, 140, "R10");

      // R11: one-cycle latency
      cfg(0, 0, 0, 4'hF, 0, 0, 0, 0);
      px(40, 40, "R11");
      @(negedge clk);
      h_cnt = 10'd0; v_cnt = 9'd0;
      #1;
      checks++;
      if (sel_o != 2'd1) begin
         errors++;
         $display("FAIL R11 output moved before the edge: sel got %0d exp 1", sel_o);
      end
      @(posedge clk); @(negedge clk);
      compare("R11");

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         if (i % 16 == 0)
            cfg($urandom % 64, $urandom % 64, $urandom % 2, $urandom % 16,
                ($urandom % 4 == 0) ? $urandom % 16 : 0, $urandom % 4,
                $urandom % 8, ($urandom % 4 == 0) ? $urandom % 4 : 0);
         x0 = g_x0(); y0 = g_y0();
         if ($urandom % 4 == 0)
            px($urandom % 800, $urandom % 300, "");
         else
            px(x0 - 3 + int'($urandom % (g_w() + 6)),
               y0 - 3 + int'($urandom % (g_n() * g_h() + 6)), "");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule